// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block controls a parameterised number of general-purpose pins (a multiple of 32, 64 by default) from a 32-bit word-addressed register bus. Each pin can be an input or an output. Output values are changed atomically through write-one set and clear registers, so software never has to read, modify and write a shared word. Input pins pass through a two-flop synchroniser. Their levels can be read back, and they can raise a sticky edge flag on a rising edge, a falling edge or both.

All edge flags are ORed into a single interrupt line. Software finds the pending pins by reading the flag words and acknowledges them by writing ones. Each pin also stores a 2-bit alternate-function code, which is driven out to the pad multiplexer. Registers are grouped by feature. Each feature has one word per 32 pins, except the alternate-function group, which has one word per 16 pins.

The bus has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational and valid in the same cycle as `bus_rd` and `bus_addr`.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: With NREG = NGPIO/32, a feature word sits at word address feature×NREG + pin/32, and the pin occupies bit pin%32 of that word. The features in order are: level 0, direction 1, output-set 2, output-clear 3, rise-enable 4, fall-enable 5, edge-flag 6, alternate-function 7. For 64 pins this gives word addresses 0..13 for features 0..6 and 14..17 for the alternate-function group.
- R2: The level words are read-only and return the synchronised pin inputs. A pin change applied before clock edge k is readable after edge k+1. Writes to the level words have no effect.
- R3: A direction bit of 1 makes the pin an output and a bit of 0 makes it an input. `pin_oe` follows the direction bits, and the direction words read back as written.
- R4: Each 1 written to an output-set word drives that pin's `pin_out` high, and each 1 written to an output-clear word drives it low. Zero bits leave the pin unchanged. Reading either word returns the current output latch.
- R5: A rising edge on a pin whose rise-enable bit is 1 sets that pin's edge flag. The flag becomes visible after clock edge k+2 for a pin change applied before edge k.
- R6: A falling edge sets the flag only when the fall-enable bit is 1. With both enables set, either edge sets the flag. With neither enable set, no edge sets it.
- R7: Writing 1 to an edge-flag bit clears it. Zero bits of the written word leave their flags unchanged.
- R8: An edge that sets a flag in the same cycle as a write-one clear of that flag leaves the flag set.
- R9: The alternate-function code of pin p is at word 7×NREG + p/16, bits 2×(p%16)+1 down to 2×(p%16). It is driven on `alt_sel[2p+1:2p]` and reads back as written.
- R10: Reset clears direction, output latch, rise and fall enables, edge flags and alternate-function codes.
- R11: `irq` is high exactly while at least one edge flag is set. It stays high until the last flag is cleared.
- R12: Word addresses at or above 9×NREG read as zero and ignore writes. `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NGPIO | Raw pin inputs |
| pin_oe | output | NGPIO | Per-pin output enable |
| pin_out | output | NGPIO | Per-pin output value |
| alt_sel | output | 2×NGPIO | Per-pin alternate-function codes |
| irq | output | 1 | Combined edge interrupt |

## Verification
The hardest situation to reach is a write-one clear that lands on exactly the clock edge where a new edge on the same pin sets its flag. The stimulus first leaves the flag set from an earlier falling edge. It then raises the pin and counts two falling clock edges through the synchroniser, so that the clear write is sampled on the third rising edge. The flag must still read as set afterwards. A plain clear with no coinciding edge is then applied to show that the write itself did take effect.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FEAT_LEVEL = 3'd0,
    FEAT_DIR   = 3'd1,
    FEAT_SET   = 3'd2,
    FEAT_CLR   = 3'd3,
    FEAT_RISE  = 3'd4,
    FEAT_FALL  = 3'd5,
    FEAT_STAT  = 3'd6,
    FEAT_ALT   = 3'd7
  } feat_e;

  function automatic int feat_base(feat_e f, int nreg);
    return int'(f) * nreg;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/gpio_word_bank.sv
module gpio_word_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int NWORDS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWORDS-1:0]        we,
  input  logic [WORD_W-1:0]        wdata,
  output logic [NWORDS*WORD_W-1:0] q
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (we[w]) word_q <= wdata;
    end
    assign q[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] hit;

  // An edge is a difference between this sample and the last one.
  assign hit = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl;
      // A new hit wins over a simultaneous clear.
      flag_q <= (flag_q & ~clr) | hit;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NGPIO-1:0]    pin_in,
  output logic [NGPIO-1:0]    pin_oe,
  output logic [NGPIO-1:0]    pin_out,
  output logic [2*NGPIO-1:0]  alt_sel,
  output logic                irq
);
  localparam int NREG = NGPIO / WORD_W;
  localparam int NALT = 2 * NREG;

  int addr_i;
  assign addr_i = int'(bus_addr);

  logic [NREG-1:0]  we_dir, we_set, we_clr, we_rise, we_fall, we_stat;
  logic [NALT-1:0]  we_alt;
  logic [NGPIO-1:0] set_mask, clr_mask, stat_clr;
  logic [NGPIO-1:0] lvl, dir_q, rise_q, fall_q, stat_q, out_q;
  logic [2*NGPIO-1:0] alt_q;
  logic [WORD_W-1:0]  rd_word;

  // Per-word write strobes
  for (genvar w = 0; w < NREG; w++) begin : g_we
    assign we_dir[w]  = bus_wr && (addr_i == feat_base(FEAT_DIR,  NREG) + w);
    assign we_set[w]  = bus_wr && (addr_i == feat_base(FEAT_SET,  NREG) + w);
    assign we_clr[w]  = bus_wr && (addr_i == feat_base(FEAT_CLR,  NREG) + w);
    assign we_rise[w] = bus_wr && (addr_i == feat_base(FEAT_RISE, NREG) + w);
    assign we_fall[w] = bus_wr && (addr_i == feat_base(FEAT_FALL, NREG) + w);
    assign we_stat[w] = bus_wr && (addr_i == feat_base(FEAT_STAT, NREG) + w);
  end
  for (genvar w = 0; w < NALT; w++) begin : g_we_alt
    assign we_alt[w] = bus_wr && (addr_i == feat_base(FEAT_ALT, NREG) + w);
  end

  // Write-one masks, one bit per pin
  for (genvar p = 0; p < NGPIO; p++) begin : g_mask
    assign set_mask[p] = we_set[p/WORD_W]  & bus_wdata[p%WORD_W];
    assign clr_mask[p] = we_clr[p/WORD_W]  & bus_wdata[p%WORD_W];
    assign stat_clr[p] = we_stat[p/WORD_W] & bus_wdata[p%WORD_W];
  end

  gpio_in_sync #(.W(NGPIO)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl)
  );

  gpio_word_bank #(.NWORDS(NREG)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(we_dir), .wdata(bus_wdata), .q(dir_q)
  );
  gpio_word_bank #(.NWORDS(NREG)) u_rise (
    .clk(clk), .rst_n(rst_n), .we(we_rise), .wdata(bus_wdata), .q(rise_q)
  );
  gpio_word_bank #(.NWORDS(NREG)) u_fall (
    .clk(clk), .rst_n(rst_n), .we(we_fall), .wdata(bus_wdata), .q(fall_q)
  );
  gpio_word_bank #(.NWORDS(NALT)) u_alt (
    .clk(clk), .rst_n(rst_n), .we(we_alt), .wdata(bus_wdata), .q(alt_q)
  );

  gpio_edge_bank #(.W(NGPIO)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise_en(rise_q),
    .fall_en(fall_q), .clr(stat_clr), .flags(stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= (out_q | set_mask) & ~clr_mask;
  end

  // Read multiplexer
  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NREG; w++) begin
      if (addr_i == feat_base(FEAT_LEVEL, NREG) + w) rd_word = lvl[w*WORD_W +: WORD_W];
      if (addr_i == feat_base(FEAT_DIR,   NREG) + w) rd_word = dir_q[w*WORD_W +: WORD_W];
      if (addr_i == feat_base(FEAT_SET,   NREG) + w) rd_word = out_q[w*WORD_W +: WORD_W];
      if (addr_i == feat_base(FEAT_CLR,   NREG) + w) rd_word = out_q[w*WORD_W +: WORD_W];
      if (addr_i == feat_base(FEAT_RISE,  NREG) + w) rd_word = rise_q[w*WORD_W +: WORD_W];
      if (addr_i == feat_base(FEAT_FALL,  NREG) + w) rd_word = fall_q[w*WORD_W +: WORD_W];
      if (addr_i == feat_base(FEAT_STAT,  NREG) + w) rd_word = stat_q[w*WORD_W +: WORD_W];
    end
    for (int w = 0; w < NALT; w++) begin
      if (addr_i == feat_base(FEAT_ALT, NREG) + w) rd_word = alt_q[w*WORD_W +: WORD_W];
    end
  end

  assign bus_rdata = bus_rd ? rd_word : '0;
  assign pin_oe    = dir_q;
  assign pin_out   = out_q;
  assign alt_sel   = alt_q;
  assign irq       = |stat_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NGPIO-1:0]  pin_out,
  input logic              irq,
  input logic [NGPIO-1:0]  stat,
  input logic [NGPIO-1:0]  rise,
  input logic [NGPIO-1:0]  fall
);
  localparam int NREG = NGPIO / 32;
  int  a;
  logic set0_wr, clr0_wr, stat_wr;
  assign a       = int'(bus_addr);
  assign set0_wr = bus_wr && (a == 2*NREG);
  assign clr0_wr = bus_wr && (a == 3*NREG);
  assign stat_wr = bus_wr && (a >= 6*NREG) && (a < 7*NREG);

  assert_set_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set0_wr |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr0_wr |=> ((pin_out[31:0] & $past(bus_wdata)) == 32'd0));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~($past(rise) | $past(fall))) == '0));

  assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_wr));

  assert_undef_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && a >= 9*NREG) |-> (bus_rdata == 32'd0));

  assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 32'd0));

  assert_reset_zero_R10: assert property (@(posedge clk)
    !rst_n |=> (stat == '0 && rise == '0 && fall == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NGPIO(NGPIO), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .irq(irq), .stat(stat_q), .rise(rise_q), .fall(fall_q)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
  localparam int NGPIO = 64;
  localparam int AW    = 8;
  localparam int NV    = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NGPIO-1:0] pin_in = '0;
  logic [NGPIO-1:0] pin_oe, pin_out;
  logic [2*NGPIO-1:0] alt_sel;
  logic            irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl #(.NGPIO(NGPIO), .ADDR_W(AW)) u_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .alt_sel(alt_sel), .irq(irq)
  );

  // {requirement, address, write data, expected read-back}
  localparam logic [79:0] VEC [NV] = '{
    {8'd3,  8'd2,   32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R3 direction word 0
    {8'd3,  8'd3,   32'h1234_5678, 32'h1234_5678},  // R3 direction word 1
    {8'd4,  8'd4,   32'h0000_00FF, 32'h0000_00FF},  // R4 set word 0
    {8'd4,  8'd6,   32'h0000_000F, 32'h0000_00F0},  // R4 clear word 0
    {8'd4,  8'd5,   32'h8000_0001, 32'h8000_0001},  // R4 set word 1
    {8'd4,  8'd7,   32'h0000_0000, 32'h8000_0001},  // R4 clear with zeros
    {8'd9,  8'd14,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R9 alt word 0
    {8'd9,  8'd17,  32'h0000_0003, 32'h0000_0003},  // R9 alt word 3
    {8'd2,  8'd0,   32'hFFFF_FFFF, 32'h0000_0000},  // R2 level ignores write
    {8'd12, 8'd18,  32'hFFFF_FFFF, 32'h0000_0000},  // R12 first undefined word
    {8'd12, 8'd255, 32'hFFFF_FFFF, 32'h0000_0000},  // R12 top address
    {8'd1,  8'd9,   32'h0000_0F00, 32'h0000_0F00},  // R1 rise word 1
    {8'd1,  8'd9,   32'h0000_0000, 32'h0000_0000},
    {8'd1,  8'd10,  32'h0000_0001, 32'h0000_0001},  // R1 fall word 0
    {8'd1,  8'd10,  32'h0000_0000, 32'h0000_0000},
    {8'd7,  8'd12,  32'hFFFF_FFFF, 32'h0000_0000}   // R7 clearing idle flags
  };

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data);
    bus_rd = 1'b1; bus_addr = AW'(addr);
    #1 data = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    wait_neg(3);
    // R10 reset state
    check("R10", pin_oe, '0);
    check("R10", pin_out, '0);
    check("R10", alt_sel, '0);
    check("R11", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(12, rd); check("R10", rd, 32'd0);
    bus_read(8,  rd); check("R10", rd, 32'd0);
    check("R12", bus_rdata, 32'd0);

    for (int i = 0; i < NV; i++) begin
      bus_write(int'(VEC[i][71:64]), VEC[i][63:32]);
      bus_read(int'(VEC[i][71:64]), rd);
      n_chk++;
      if (rd !== VEC[i][31:0]) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: got %h expected %h", VEC[i][79:72], i, rd, VEC[i][31:0]);
      end
    end

    // R1 R3 R4 R9 pin-side views of the vector writes
    check("R3", pin_oe, {32'h1234_5678, 32'hA5A5_0F0F});
    check("R4", pin_out, {32'h8000_0001, 32'h0000_00F0});
    check("R9", alt_sel[31:0], 32'hDEAD_BEEF);
    check("R9", alt_sel[97:96], 2'd3);
    check("R1", alt_sel[127:98], '0);

    // R2 synchroniser latency on pin 37
    pin_in[37] = 1'b1;
    @(negedge clk);
    bus_read(1, rd); check("R2", rd, 32'd0);
    @(negedge clk);
    bus_read(1, rd); check("R2", rd, 32'h20);

    // R6 falling edge without fall enable
    bus_write(9, 32'h20);
    pin_in[37] = 1'b0;
    wait_neg(4);
    bus_read(13, rd); check("R6", rd, 32'd0);
    check("R11", irq, 1'b0);

    // R5 rising edge latency
    pin_in[37] = 1'b1;
    wait_neg(2);
    bus_read(13, rd); check("R5", rd, 32'd0);
    wait_neg(1);
    bus_read(13, rd); check("R5", rd, 32'h20);
    check("R11", irq, 1'b1);

    // R7 zero bits keep flags, one bits clear
    bus_write(13, 32'hFFFF_FFDF);
    bus_read(13, rd); check("R7", rd, 32'h20);
    bus_write(13, 32'h20);
    bus_read(13, rd); check("R7", rd, 32'd0);
    check("R11", irq, 1'b0);

    // R6 both enables on pin 3
    bus_write(8, 32'h8);
    bus_write(10, 32'h8);
    pin_in[3] = 1'b1;
    wait_neg(3);
    bus_read(12, rd); check("R5", rd, 32'h8);
    bus_write(12, 32'h8);
    bus_read(12, rd); check("R7", rd, 32'd0);
    pin_in[3] = 1'b0;
    wait_neg(3);
    bus_read(12, rd); check("R6", rd, 32'h8);

    // R8 clear on the very edge that sets the flag again
    pin_in[3] = 1'b1;
    wait_neg(2);
    bus_write(12, 32'h8);
    bus_read(12, rd); check("R8", rd, 32'h8);
    bus_write(12, 32'h8);
    bus_read(12, rd); check("R8", rd, 32'd0);

    // R11 two pending flags
    pin_in[37] = 1'b0;
    wait_neg(3);
    pin_in[37] = 1'b1;
    pin_in[3]  = 1'b0;
    wait_neg(3);
    bus_read(12, rd); check("R6", rd, 32'h8);
    bus_read(13, rd); check("R5", rd, 32'h20);
    bus_write(13, 32'h20);
    check("R11", irq, 1'b1);
    bus_write(12, 32'h8);
    check("R11", irq, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule